// File: doc/BRIEF.md
# Register Rename Map with Committed Checkpoint

This block sits in the front end of an out-of-order core. It translates the architectural register names used by the instruction stream into physical register names. It keeps two tables, each holding one physical register per logical register. The speculative table follows every renamed instruction. The committed table follows only retired instructions. Unused physical registers wait in a first-in first-out pool, so a rename takes the register at the head of the pool and a commit puts a register back at the tail.

Each rename request names two sources and one destination. In the same cycle the block returns the physical names of both sources, a fresh physical register for the destination, and the physical register that the destination replaced. Commit carries no data. It records the new physical register in the committed table and returns the register that the committed table held before. A flush discards all speculative state. The speculative table becomes a copy of the committed table, and the pool is rebuilt from every physical register that the committed table does not use.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register i (0..31) maps to physical register i, and the pool hands out physical registers 32..63 in ascending order. The rename port is ready.
- R2: In the request cycle, ren_psrc0 and ren_psrc1 give the current speculative mapping of the two sources. When a source equals the destination of the same request, it gets the mapping from before that request.
- R3: An accepted rename (ren_valid and ren_ready both high at a rising edge) returns the head of the pool on ren_pdst and the old speculative mapping of the destination on ren_pold. From the next cycle on, readers of that logical register receive ren_pdst.
- R4: ren_ready is low while the pool is empty. A request made while ren_ready is low changes neither the mapping nor the pool.
- R5: A commit (cmt_valid high) writes cmt_pdst into the committed entry of cmt_dst and leaves the speculative table unchanged.
- R6: Outside a flush, a commit appends the physical register that the committed entry held before to the tail of the pool. A rename can allocate that register from the next cycle on.
- R7: When flush is high, ren_ready is low and no rename is accepted. In the next cycle the speculative table equals the committed table, including a commit made in the flush cycle. The pool then holds the 32 physical registers that the committed table does not use, in ascending order.
- R8: A rename and a commit in the same cycle both take effect. The allocation takes the old head of the pool, and the released register joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_src0 | input | 5 | First source logical register |
| ren_src1 | input | 5 | Second source logical register |
| ren_dst | input | 5 | Destination logical register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_psrc0 | output | 6 | Physical name of first source |
| ren_psrc1 | output | 6 | Physical name of second source |
| ren_pdst | output | 6 | Newly allocated physical destination |
| ren_pold | output | 6 | Previous speculative mapping of the destination |
| cmt_valid | input | 1 | Commit of the oldest renamed instruction |
| cmt_dst | input | 5 | Committed destination logical register |
| cmt_pdst | input | 6 | Physical register given to that destination at rename |
| flush | input | 1 | Discard speculative state |

## Verification
The rename outputs are combinational. ren_ready, both source names, ren_pdst and ren_pold are due in the request cycle itself, so the bench drives each request on the falling edge and samples 1 ns later, before the rising edge that accepts it. Updates to the tables and the pool are due one rising edge later. The bench sees them only through the next cycle's outputs: the source names, the allocated register and ready. Its reference model updates right after each sample, so every expected value matches the cycle in which the block can show it.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    parameter int unsigned LOGICAL_REGS  = 32;
    parameter int unsigned PHYSICAL_REGS = 64;

    localparam int unsigned LW        = $clog2(LOGICAL_REGS);
    localparam int unsigned PW        = $clog2(PHYSICAL_REGS);
    localparam int unsigned CW        = $clog2(PHYSICAL_REGS + 1);
    localparam int unsigned SPARE_CNT = PHYSICAL_REGS - LOGICAL_REGS;

    typedef logic [LW-1:0] lreg_t;
    typedef logic [PW-1:0] preg_t;
    typedef logic [CW-1:0] pcnt_t;

    typedef preg_t [LOGICAL_REGS-1:0] map_t;

    typedef struct packed {
        logic  valid;
        lreg_t src0;
        lreg_t src1;
        lreg_t dst;
    } ren_req_t;

    typedef struct packed {
        preg_t psrc0;
        preg_t psrc1;
        preg_t pdst;
        preg_t pold;
    } ren_rsp_t;

    typedef struct packed {
        logic  valid;
        lreg_t dst;
        preg_t pdst;
    } cmt_req_t;

    function automatic preg_t boot_phys(input int unsigned lidx);
        return preg_t'(lidx);
    endfunction

    function automatic preg_t ptr_inc(input preg_t p);
        return (int'(p) == PHYSICAL_REGS - 1) ? '0 : p + preg_t'(1);
    endfunction
endpackage

// File: rtl/rmap_table.sv
module rmap_table
    import rmap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  lreg_t wr_idx,
    input  preg_t wr_val,
    input  logic  restore_en,
    input  map_t  restore_map,
    output map_t  map_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LOGICAL_REGS; i++) begin
                map_o[i] <= boot_phys(i);
            end
        end else if (restore_en) begin
            map_o <= restore_map;
        end else if (wr_en) begin
            map_o[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/rmap_freelist.sv
module rmap_freelist
    import rmap_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc,
    input  logic                     release_en,
    input  preg_t                    release_val,
    input  logic                     rebuild,
    input  logic [PHYSICAL_REGS-1:0] in_use,
    output preg_t                    head_val,
    output pcnt_t                    count
);
    preg_t slots [PHYSICAL_REGS];
    preg_t head_ptr;
    preg_t tail_ptr;

    preg_t fill_val [PHYSICAL_REGS];
    pcnt_t fill_cnt;

    always_comb begin
        fill_cnt = '0;
        for (int p = 0; p < PHYSICAL_REGS; p++) begin
            fill_val[p] = '0;
        end
        for (int p = 0; p < PHYSICAL_REGS; p++) begin
            if (!in_use[p]) begin
                fill_val[fill_cnt[PW-1:0]] = preg_t'(p);
                fill_cnt = fill_cnt + pcnt_t'(1);
            end
        end
    end

    assign head_val = slots[head_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYSICAL_REGS; i++) begin
                slots[i] <= (i < SPARE_CNT) ? preg_t'(LOGICAL_REGS + i) : '0;
            end
            head_ptr <= '0;
            tail_ptr <= preg_t'(SPARE_CNT);
            count    <= pcnt_t'(SPARE_CNT);
        end else if (rebuild) begin
            for (int i = 0; i < PHYSICAL_REGS; i++) begin
                slots[i] <= fill_val[i];
            end
            head_ptr <= '0;
            tail_ptr <= fill_cnt[PW-1:0];
            count    <= fill_cnt;
        end else begin
            if (alloc) begin
                head_ptr <= ptr_inc(head_ptr);
            end
            if (release_en) begin
                slots[tail_ptr] <= release_val;
                tail_ptr        <= ptr_inc(tail_ptr);
            end
            count <= count + pcnt_t'(release_en) - pcnt_t'(alloc);
        end
    end

    // R4: never allocate from an empty pool
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        alloc |-> count != '0);

    // R6: a release never pushes the pool past its capacity
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (release_en && !rebuild) |-> int'(count) < PHYSICAL_REGS);

    // R6: a lone release grows the pool by one
    assert_release_grows_R6: assert property (@(posedge clk) disable iff (rst)
        (release_en && !alloc && !rebuild) |=> count == $past(count) + pcnt_t'(1));
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
    import rmap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_valid,
    input  logic [LW-1:0] ren_src0,
    input  logic [LW-1:0] ren_src1,
    input  logic [LW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] ren_psrc0,
    output logic [PW-1:0] ren_psrc1,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_pold,
    input  logic          cmt_valid,
    input  logic [LW-1:0] cmt_dst,
    input  logic [PW-1:0] cmt_pdst,
    input  logic          flush
);
    ren_req_t req;
    ren_rsp_t rsp;
    cmt_req_t cmt;

    map_t  spec_map;
    map_t  arch_map;
    map_t  arch_next;
    preg_t pool_head;
    pcnt_t pool_count;
    logic  ren_fire;
    logic  do_release;
    logic [PHYSICAL_REGS-1:0] arch_used;

    assign req = '{valid: ren_valid, src0: ren_src0, src1: ren_src1, dst: ren_dst};
    assign cmt = '{valid: cmt_valid, dst: cmt_dst, pdst: cmt_pdst};

    // sources read the table before this request's destination is written
    assign rsp.psrc0 = spec_map[req.src0];
    assign rsp.psrc1 = spec_map[req.src1];
    assign rsp.pdst  = pool_head;
    assign rsp.pold  = spec_map[req.dst];

    assign ren_ready  = (pool_count != '0) && !flush;
    assign ren_fire   = req.valid && ren_ready;
    assign do_release = cmt.valid && !flush;

    assign ren_psrc0 = rsp.psrc0;
    assign ren_psrc1 = rsp.psrc1;
    assign ren_pdst  = rsp.pdst;
    assign ren_pold  = rsp.pold;

    always_comb begin
        arch_next = arch_map;
        if (cmt.valid) begin
            arch_next[cmt.dst] = cmt.pdst;
        end
        arch_used = '0;
        for (int l = 0; l < LOGICAL_REGS; l++) begin
            arch_used[arch_next[l]] = 1'b1;
        end
    end

    rmap_table u_spec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ren_fire),
        .wr_idx      (req.dst),
        .wr_val      (rsp.pdst),
        .restore_en  (flush),
        .restore_map (arch_next),
        .map_o       (spec_map)
    );

    rmap_table u_arch (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cmt.valid),
        .wr_idx      (cmt.dst),
        .wr_val      (cmt.pdst),
        .restore_en  (1'b0),
        .restore_map ('0),
        .map_o       (arch_map)
    );

    rmap_freelist u_pool (
        .clk         (clk),
        .rst         (rst),
        .alloc       (ren_fire),
        .release_en  (do_release),
        .release_val (arch_map[cmt.dst]),
        .rebuild     (flush),
        .in_use      (arch_used),
        .head_val    (pool_head),
        .count       (pool_count)
    );

    // R1: leaving reset, the pool holds exactly the spare registers
    assert_boot_pool_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> int'(pool_count) == SPARE_CNT);

    // R3: an accepted rename is visible in the speculative table next cycle
    assert_rename_write_R3: assert property (@(posedge clk) disable iff (rst)
        ren_fire |=> spec_map[$past(req.dst)] == $past(rsp.pdst));

    // R5: a commit lands in the committed table
    assert_commit_write_R5: assert property (@(posedge clk) disable iff (rst)
        cmt.valid |=> arch_map[$past(cmt.dst)] == $past(cmt.pdst));

    // R7: after a flush the speculative table equals the committed table
    assert_flush_restore_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> spec_map == arch_map);

    // R7: after a flush the pool holds the spare count again
    assert_flush_pool_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> int'(pool_count) == SPARE_CNT);
endmodule

// File: tb/sim_rename_map_unit.sv
`timescale 1ns/1ps
module sim_rename_map_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       ren_valid;
    logic [4:0] ren_src0, ren_src1, ren_dst;
    logic       ren_ready;
    logic [5:0] ren_psrc0, ren_psrc1, ren_pdst, ren_pold;
    logic       cmt_valid;
    logic [4:0] cmt_dst;
    logic [5:0] cmt_pdst;
    logic       flush;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    int smap_m [32];
    int cmap_m [32];
    int fq [$];
    int rob_d [$];
    int rob_p [$];

    always #2 clk = ~clk;

    rename_map_unit u0 (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .ren_psrc0(ren_psrc0), .ren_psrc1(ren_psrc1),
        .ren_pdst(ren_pdst), .ren_pold(ren_pold),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_pdst(cmt_pdst),
        .flush(flush)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) begin
            smap_m[i] = i;
            cmap_m[i] = i;
        end
        fq.delete();
        for (int p = 32; p < 64; p++) fq.push_back(p);
        rob_d.delete();
        rob_p.delete();
    endfunction

    // one cycle: drive on falling edge, sample before the rising edge, advance the model
    task automatic step(input bit v, input int s0, input int s1, input int d,
                        input bit cv, input bit fl, input string tag);
        bit exp_rdy;
        int cd, cp, old;
        @(negedge clk);
        cd = 0; cp = 0;
        if (cv) begin
            cd = rob_d[0];
            cp = rob_p[0];
        end
        ren_valid = v;
        ren_src0 = 5'(s0); ren_src1 = 5'(s1); ren_dst = 5'(d);
        cmt_valid = cv; cmt_dst = 5'(cd); cmt_pdst = 6'(cp);
        flush = fl;
        #1;
        exp_rdy = (fq.size() != 0) && !fl;
        check(fl ? "R7" : "R4", {tag, " ready"}, int'(ren_ready), int'(exp_rdy));
        if (v && exp_rdy) begin
            check("R2", {tag, " psrc0"}, int'(ren_psrc0), smap_m[s0]);
            check("R2", {tag, " psrc1"}, int'(ren_psrc1), smap_m[s1]);
            check("R3", {tag, " pdst"}, int'(ren_pdst), fq[0]);
            check("R3", {tag, " pold"}, int'(ren_pold), smap_m[d]);
        end
        if (fl) begin
            bit used [64];
            if (cv) cmap_m[cd] = cp;
            for (int p = 0; p < 64; p++) used[p] = 0;
            for (int i = 0; i < 32; i++) begin
                smap_m[i] = cmap_m[i];
                used[cmap_m[i]] = 1;
            end
            fq.delete();
            for (int p = 0; p < 64; p++) if (!used[p]) fq.push_back(p);
            rob_d.delete();
            rob_p.delete();
        end else begin
            if (v && exp_rdy) begin
                int pd;
                pd = fq.pop_front();
                smap_m[d] = pd;
                rob_d.push_back(d);
                rob_p.push_back(pd);
            end
            if (cv) begin
                old = cmap_m[cd];
                cmap_m[cd] = cp;
                fq.push_back(old);
                void'(rob_d.pop_front());
                void'(rob_p.pop_front());
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        rst = 1'b1; ren_valid = 0; ren_src0 = 0; ren_src1 = 0; ren_dst = 0;
        cmt_valid = 0; cmt_dst = 0; cmt_pdst = 0; flush = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "ready after reset", int'(ren_ready), 1);

        // R1, R2: identity map, first allocation is 32; self read sees old name
        step(1, 5, 7, 5, 0, 0, "R1 first rename");
        step(1, 5, 5, 9, 0, 0, "R3 reader of new name");
        // R4: drain the pool completely, then stalled requests
        for (int k = 0; k < 34; k++) step(1, k % 32, (k + 3) % 32, (k * 7) % 32, 0, 0, "R4 drain");
        step(1, 1, 2, 3, 0, 0, "R4 stalled");
        // R6: commit frees a register usable in the next cycle
        step(0, 0, 0, 0, 1, 0, "R6 release");
        step(1, 4, 5, 6, 0, 0, "R6 reuse");
        // R8: rename and commit together
        step(1, 8, 9, 10, 1, 0, "R8 combined");
        // R7: flush with a commit in the same cycle and a request that is ignored
        step(1, 1, 2, 3, 1, 1, "R7 flush");
        step(1, 5, 9, 5, 0, 0, "R7 after flush");

        for (int c = 0; c < 4000; c++) begin
            bit v, cv, fl;
            fl = ($urandom % 97) == 0;
            v  = ($urandom % 4) != 0;
            cv = (rob_d.size() != 0) && (($urandom % 3) == 0);
            step(v, $urandom % 32, $urandom % 32, $urandom % 32, cv, fl, "R5 random");
        end

        // R5: retire everything in flight, then flush; names must match committed state
        while (rob_d.size() != 0) step(0, 0, 0, 0, 1, 0, "R5 drain commits");
        step(0, 0, 0, 0, 0, 1, "R7 final flush");
        for (int i = 0; i < 32; i++) step(1, i, (i + 1) % 32, i, 0, 0, "R5 committed view");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule